// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address, made of a segment number and an offset, into a physical address. It holds a small segment table in flops. Each entry stores a base address, a length limit, a valid flag and three permission flags for read, write and execute. Software fills the table through a write port. A separate segment-count register sets how many table slots are in use.

Each request carries a segment number, an offset and an access kind. The block checks the request for four kinds of fault:

- the segment number is out of range;
- the table entry is invalid;
- the offset is past the segment length;
- the access kind is not permitted.

If none of these apply, the block returns base plus offset. The result is registered and appears one cycle after the request, either as an address or as a fault code. A faulting request always returns an address of zero.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the response outputs are all zero, the segment count is zero and every table entry is invalid.
- R2: A response is presented with rsp_valid_o high in exactly the cycle after a request is accepted. Without a request in the previous cycle, rsp_valid_o is low and rsp_fault_o and rsp_paddr_o are zero.
- R3: For a legal request, rsp_fault_o is 0 and rsp_paddr_o equals (base + offset) modulo 2^PA_W.
- R4: A segment number greater than or equal to the segment count gives fault code 1 (segment out of range).
- R5: A segment whose entry has its valid flag clear gives fault code 2 (invalid entry).
- R6: An offset that is not strictly less than the entry limit gives fault code 3 (offset over limit). A limit of zero therefore rejects every offset.
- R7: The access kind is encoded as 0 for read, 1 for write, 2 for execute and 3 reserved. The permission field uses bit 0 for read, bit 1 for write and bit 2 for execute. A kind whose bit is clear, and the reserved kind in all cases, gives fault code 4 (permission).
- R8: When several faults apply, the code reported is the first one in the order 1, 2, 3, 4.
- R9: Whenever rsp_fault_o is non-zero, rsp_paddr_o is zero.
- R10: A table write or segment-count write is seen only by requests from the following cycle onward. A request in the same cycle still sees the old contents. A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_seg_i | input | IDX_W (4) | Segment number |
| req_off_i | input | OFF_W (12) | Offset within the segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_wr_en_i | input | 1 | Write one table entry |
| cfg_wr_idx_i | input | IDX_W (4) | Entry index to write |
| cfg_wr_base_i | input | PA_W (16) | Entry base address |
| cfg_wr_limit_i | input | OFF_W+1 (13) | Entry length |
| cfg_wr_valid_i | input | 1 | Entry valid flag |
| cfg_wr_perm_i | input | 3 | Entry permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_cnt_wr_i | input | 1 | Load the segment count |
| cfg_cnt_i | input | CNT_W (5) | New segment count |
| rsp_valid_o | output | 1 | Response present |
| rsp_paddr_o | output | PA_W (16) | Physical address, zero on fault |
| rsp_fault_o | output | 3 | Fault code: 0 none, 1 range, 2 invalid, 3 limit, 4 permission |

## Verification
Every response is due one clock edge after its request. The bench drives a request on a falling edge, removes it on the next falling edge, and samples the outputs at that moment, after the registering edge and before the next one. Idle outputs are sampled one further falling edge later, once a cycle without a request has passed through the register. Table and count writes are applied in the same way. For the case of a request in the same cycle as a write, both are driven on the same falling edge, so the request must see the old contents. The next request must see the new ones.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SEG_RANGE = 3'd1,
    FLT_INVALID   = 3'd2,
    FLT_LIMIT     = 3'd3,
    FLT_PERM      = 3'd4
  } fault_e;

  localparam int unsigned PERM_W  = 3;
  localparam int unsigned FAULT_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned PA_W    = 16,
  parameter int unsigned LIM_W   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              wr_valid_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PA_W-1:0]   rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic              rd_valid_o,
  output logic [PERM_W-1:0] rd_perm_o
);

  logic [PA_W-1:0]   base_q  [NUM_SEG];
  logic [LIM_W-1:0]  limit_q [NUM_SEG];
  logic              valid_q [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];

  for (genvar e = 0; e < NUM_SEG; e++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[e]  <= '0;
        limit_q[e] <= '0;
        valid_q[e] <= 1'b0;
        perm_q[e]  <= '0;
      end else if (hit) begin
        base_q[e]  <= wr_base_i;
        limit_q[e] <= wr_limit_i;
        valid_q[e] <= wr_valid_i;
        perm_q[e]  <= wr_perm_i;
      end
    end
  end

  // Indices past the populated slots read as an empty entry.
  logic rd_in_tbl;
  assign rd_in_tbl = 32'(rd_idx_i) < NUM_SEG;

  always_comb begin
    rd_base_o  = '0;
    rd_limit_o = '0;
    rd_valid_o = 1'b0;
    rd_perm_o  = '0;
    if (rd_in_tbl) begin
      rd_base_o  = base_q[rd_idx_i];
      rd_limit_o = limit_q[rd_idx_i];
      rd_valid_o = valid_q[rd_idx_i];
      rd_perm_o  = perm_q[rd_idx_i];
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned LIM_W = 13,
  parameter int unsigned PA_W  = 16
) (
  input  logic [IDX_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_e              acc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PA_W-1:0]   ent_base_i,
  input  logic [LIM_W-1:0]  ent_limit_i,
  input  logic              ent_valid_i,
  input  logic [PERM_W-1:0] ent_perm_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);

  logic seg_ok, off_ok, perm_ok;
  logic [PA_W-1:0] sum;

  // All comparisons evaluate in parallel; only the final select is ordered.
  assign seg_ok = CNT_W'(seg_i) < cnt_i;
  assign off_ok = LIM_W'(off_i) < ent_limit_i;
  assign sum    = ent_base_i + PA_W'(off_i);

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm_ok = ent_perm_i[0];
      ACC_WRITE: perm_ok = ent_perm_i[1];
      ACC_EXEC:  perm_ok = ent_perm_i[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!seg_ok)           fault_o = FLT_SEG_RANGE;
    else if (!ent_valid_i) fault_o = FLT_INVALID;
    else if (!off_ok)      fault_o = FLT_LIMIT;
    else if (!perm_ok)     fault_o = FLT_PERM;
    else                   fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 16,
  localparam int unsigned IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int unsigned CNT_W  = $clog2(NUM_SEG + 1),
  localparam int unsigned LIM_W  = OFF_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [IDX_W-1:0]   req_seg_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [1:0]         req_acc_i,
  input  logic               cfg_wr_en_i,
  input  logic [IDX_W-1:0]   cfg_wr_idx_i,
  input  logic [PA_W-1:0]    cfg_wr_base_i,
  input  logic [LIM_W-1:0]   cfg_wr_limit_i,
  input  logic               cfg_wr_valid_i,
  input  logic [2:0]         cfg_wr_perm_i,
  input  logic               cfg_cnt_wr_i,
  input  logic [CNT_W-1:0]   cfg_cnt_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic [2:0]         rsp_fault_o
);

  logic [CNT_W-1:0]  cnt_q;
  logic [PA_W-1:0]   ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  fault_e            fault_d;
  logic [PA_W-1:0]   paddr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cfg_cnt_wr_i) cnt_q <= cfg_cnt_i;
  end

  seg_table #(
    .NUM_SEG (NUM_SEG),
    .IDX_W   (IDX_W),
    .PA_W    (PA_W),
    .LIM_W   (LIM_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_wr_en_i),
    .wr_idx_i   (cfg_wr_idx_i),
    .wr_base_i  (cfg_wr_base_i),
    .wr_limit_i (cfg_wr_limit_i),
    .wr_valid_i (cfg_wr_valid_i),
    .wr_perm_i  (cfg_wr_perm_i),
    .rd_idx_i   (req_seg_i),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_valid_o (ent_valid),
    .rd_perm_o  (ent_perm)
  );

  seg_check #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .OFF_W (OFF_W),
    .LIM_W (LIM_W),
    .PA_W  (PA_W)
  ) u_check (
    .seg_i       (req_seg_i),
    .off_i       (req_off_i),
    .acc_i       (acc_e'(req_acc_i)),
    .cnt_i       (cnt_q),
    .ent_base_i  (ent_base),
    .ent_limit_i (ent_limit),
    .ent_valid_i (ent_valid),
    .ent_perm_i  (ent_perm),
    .fault_o     (fault_d),
    .paddr_o     (paddr_d)
  );

  // Idle cycles clear the response so stale addresses never linger.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? paddr_d : '0;
      rsp_fault_o <= req_valid_i ? fault_d : FLT_NONE;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned PA_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [IDX_W-1:0] req_seg_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic [2:0]       rsp_fault_o
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_fault_o == 3'd0 && rsp_paddr_o == '0)); // R2

  AST_SEG_RANGE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && CNT_W'(req_seg_i) >= cnt_q) |=> (rsp_fault_o == 3'd1)); // R4

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != 3'd0) |-> (rsp_paddr_o == '0)); // R9

  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o <= 3'd4); // R8

endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .IDX_W (IDX_W),
  .CNT_W (CNT_W),
  .PA_W  (PA_W)
) u_seg_xlate_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_seg_i   (req_seg_i),
  .cnt_q       (cnt_q),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;

  localparam int NUM_SEG = 16;
  localparam int OFF_W   = 12;
  localparam int PA_W    = 16;
  localparam int IDX_W   = 4;
  localparam int CNT_W   = 5;
  localparam int LIM_W   = OFF_W + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [IDX_W-1:0] req_seg_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [1:0] req_acc_i = '0;
  logic cfg_wr_en_i = 1'b0;
  logic [IDX_W-1:0] cfg_wr_idx_i = '0;
  logic [PA_W-1:0] cfg_wr_base_i = '0;
  logic [LIM_W-1:0] cfg_wr_limit_i = '0;
  logic cfg_wr_valid_i = 1'b0;
  logic [2:0] cfg_wr_perm_i = '0;
  logic cfg_cnt_wr_i = 1'b0;
  logic [CNT_W-1:0] cfg_cnt_i = '0;
  logic rsp_valid_o;
  logic [PA_W-1:0] rsp_paddr_o;
  logic [2:0] rsp_fault_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side model of what software has written.
  logic [PA_W-1:0]  m_base [NUM_SEG];
  logic [LIM_W-1:0] m_lim  [NUM_SEG];
  logic             m_vld  [NUM_SEG];
  logic [2:0]       m_perm [NUM_SEG];
  int               m_cnt;

  always #10 clk = ~clk;

  seg_xlate_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_seg_i(req_seg_i), .req_off_i(req_off_i),
    .req_acc_i(req_acc_i),
    .cfg_wr_en_i(cfg_wr_en_i), .cfg_wr_idx_i(cfg_wr_idx_i),
    .cfg_wr_base_i(cfg_wr_base_i), .cfg_wr_limit_i(cfg_wr_limit_i),
    .cfg_wr_valid_i(cfg_wr_valid_i), .cfg_wr_perm_i(cfg_wr_perm_i),
    .cfg_cnt_wr_i(cfg_cnt_wr_i), .cfg_cnt_i(cfg_cnt_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_fault(int seg, int off, int acc);
    if (seg >= m_cnt) return 3'd1;
    if (!m_vld[seg]) return 3'd2;
    if (off >= int'(m_lim[seg])) return 3'd3;
    if (acc == 3 || !m_perm[seg][acc]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [PA_W-1:0] exp_addr(int seg, int off, int acc);
    if (exp_fault(seg, off, acc) != 3'd0) return '0;
    return PA_W'(int'(m_base[seg]) + off);
  endfunction

  task automatic wr_entry(int idx, int base, int lim, bit vld, int perm);
    @(negedge clk);
    cfg_wr_en_i = 1'b1; cfg_wr_idx_i = IDX_W'(idx); cfg_wr_base_i = PA_W'(base);
    cfg_wr_limit_i = LIM_W'(lim); cfg_wr_valid_i = vld; cfg_wr_perm_i = 3'(perm);
    @(negedge clk);
    cfg_wr_en_i = 1'b0;
    m_base[idx] = PA_W'(base); m_lim[idx] = LIM_W'(lim);
    m_vld[idx] = vld; m_perm[idx] = 3'(perm);
  endtask

  task automatic wr_count(int n);
    @(negedge clk);
    cfg_cnt_wr_i = 1'b1; cfg_cnt_i = CNT_W'(n);
    @(negedge clk);
    cfg_cnt_wr_i = 1'b0;
    m_cnt = n;
  endtask

  // Drive a request for one cycle; the response is due at the next falling edge.
  task automatic req_chk(string tag, int seg, int off, int acc, logic [2:0] ef, logic [PA_W-1:0] ea);
    @(negedge clk);
    req_valid_i = 1'b1; req_seg_i = IDX_W'(seg); req_off_i = OFF_W'(off); req_acc_i = 2'(acc);
    @(negedge clk);
    req_valid_i = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid_o), 32'd1);
    check({tag, " fault"}, 32'(rsp_fault_o), 32'(ef));
    check({tag, " paddr"}, 32'(rsp_paddr_o), 32'(ea));
  endtask

  task automatic req_model(string tag, int seg, int off, int acc);
    req_chk(tag, seg, off, acc, exp_fault(seg, off, acc), exp_addr(seg, off, acc));
  endtask

  task automatic t_reset();
    check("R1 valid after reset", 32'(rsp_valid_o), 0);
    check("R1 fault after reset", 32'(rsp_fault_o), 0);
    check("R1 paddr after reset", 32'(rsp_paddr_o), 0);
    req_chk("R1 count zero", 0, 0, 0, 3'd1, '0);
    wr_count(16);
    for (int s = 0; s < NUM_SEG; s += 5) req_chk("R1 entry invalid", s, 0, 0, 3'd2, '0);
  endtask

  task automatic t_legal();
    wr_entry(0, 'h1000, 'h100, 1, 3'b111);
    wr_entry(1, 'h4000, 'h1000, 1, 3'b011);
    wr_entry(2, 'hFF00, 'h800, 1, 3'b101);
    req_chk("R3 read", 0, 'h10, 0, 3'd0, 16'h1010);
    req_chk("R3 write", 1, 'hFFF, 1, 3'd0, 16'h4FFF);
    req_chk("R3 exec", 0, 'hFF, 2, 3'd0, 16'h10FF);
    req_chk("R3 wrap", 2, 'h200, 0, 3'd0, 16'h0100);
    // R2: back-to-back requests, then one idle cycle
    @(negedge clk);
    req_valid_i = 1'b1; req_seg_i = 4'd0; req_off_i = 12'h1; req_acc_i = 2'd0;
    @(negedge clk);
    check("R2 first of pair", 32'(rsp_paddr_o), 32'h1001);
    req_seg_i = 4'd1; req_off_i = 12'h2;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R2 second valid", 32'(rsp_valid_o), 1);
    check("R2 second of pair", 32'(rsp_paddr_o), 32'h4002);
    @(negedge clk);
    check("R2 idle valid", 32'(rsp_valid_o), 0);
    check("R2 idle fault", 32'(rsp_fault_o), 0);
    check("R2 idle paddr", 32'(rsp_paddr_o), 0);
  endtask

  task automatic t_range();
    wr_entry(3, 'h2000, 'h10, 1, 3'b111);
    wr_count(3);
    req_chk("R4 seg equals count", 3, 0, 0, 3'd1, '0);
    req_chk("R4 seg above count", 15, 0, 0, 3'd1, '0);
    req_chk("R4 seg below count", 2, 4, 0, 3'd0, 16'hFF04);
    wr_count(16);
    req_chk("R4 count raised", 3, 1, 0, 3'd0, 16'h2001);
  endtask

  task automatic t_invalid();
    wr_entry(4, 'h3000, 'h100, 0, 3'b111);
    req_chk("R5 invalid entry", 4, 0, 0, 3'd2, '0);
  endtask

  task automatic t_limit();
    wr_entry(5, 'h0500, 'h20, 1, 3'b111);
    wr_entry(6, 'h0600, 0, 1, 3'b111);
    req_chk("R6 off at limit", 5, 'h20, 0, 3'd3, '0);
    req_chk("R6 off limit-1", 5, 'h1F, 0, 3'd0, 16'h051F);
    req_chk("R6 zero limit", 6, 0, 0, 3'd3, '0);
    req_chk("R6 full size max off", 1, 'hFFF, 0, 3'd0, 16'h4FFF);
  endtask

  task automatic t_perm();
    wr_entry(7, 'h7000, 'h100, 1, 3'b001);
    wr_entry(8, 'h8000, 'h100, 1, 3'b110);
    req_chk("R7 read allowed", 7, 1, 0, 3'd0, 16'h7001);
    req_chk("R7 write denied", 7, 1, 1, 3'd4, '0);
    req_chk("R7 exec denied", 7, 1, 2, 3'd4, '0);
    req_chk("R7 read denied", 8, 1, 0, 3'd4, '0);
    req_chk("R7 exec allowed", 8, 2, 2, 3'd0, 16'h8002);
    req_chk("R7 reserved kind", 0, 1, 3, 3'd4, '0);
    for (int a = 0; a < 4; a++) req_model("R7 sweep", 1, 3, a);
  endtask

  task automatic t_priority();
    wr_entry(9, 'h9000, 0, 0, 3'b000);
    wr_entry(10, 'hA000, 4, 1, 3'b000);
    req_chk("R8 invalid over limit/perm", 9, 8, 1, 3'd2, '0);
    req_chk("R8 limit over perm", 10, 8, 1, 3'd3, '0);
    wr_count(9);
    req_chk("R8 range over all", 9, 8, 1, 3'd1, '0);
    wr_count(16);
    req_chk("R9 perm zero addr", 10, 1, 1, 3'd4, '0);
  endtask

  task automatic t_write_timing();
    wr_entry(11, 'hB000, 'h100, 1, 3'b111);
    wr_entry(12, 'hC000, 'h100, 1, 3'b111);
    @(negedge clk);
    cfg_wr_en_i = 1'b1; cfg_wr_idx_i = 4'd11; cfg_wr_base_i = 16'hD000;
    cfg_wr_limit_i = 13'h100; cfg_wr_valid_i = 1'b1; cfg_wr_perm_i = 3'b111;
    req_valid_i = 1'b1; req_seg_i = 4'd11; req_off_i = 12'h5; req_acc_i = 2'd0;
    @(negedge clk);
    cfg_wr_en_i = 1'b0; req_valid_i = 1'b0;
    check("R10 same-cycle sees old", 32'(rsp_paddr_o), 32'hB005);
    m_base[11] = 16'hD000;
    req_chk("R10 next sees new", 11, 5, 0, 3'd0, 16'hD005);
    req_chk("R10 neighbour kept", 12, 5, 0, 3'd0, 16'hC005);
    @(negedge clk);
    cfg_cnt_wr_i = 1'b1; cfg_cnt_i = 5'd0;
    req_valid_i = 1'b1; req_seg_i = 4'd12; req_off_i = 12'h6; req_acc_i = 2'd0;
    @(negedge clk);
    cfg_cnt_wr_i = 1'b0; req_valid_i = 1'b0;
    check("R10 count same-cycle old", 32'(rsp_paddr_o), 32'hC006);
    m_cnt = 0;
    req_chk("R10 count applied", 12, 6, 0, 3'd1, '0);
  endtask

  initial begin
    for (int i = 0; i < NUM_SEG; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_vld[i] = 1'b0; m_perm[i] = '0;
    end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_range();
    t_invalid();
    t_limit();
    t_perm();
    t_priority();
    t_write_timing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule